// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block models the command front end of a small parallel NOR-style flash memory. A host issues bus writes (address, data, write enable for one clock) and reads through a separate read address. Multi-write unlock sequences are decoded into three operations: byte program, whole-array erase and per-sector erase. A simulated embedded engine carries each operation out on an on-chip byte array after a fixed number of clock cycles. While work is pending, reads return a status byte in place of array data.

Sector erase requests are not acted on at once. Each one adds its sector to a pending set and (re)starts a quiet-time counter. Only when no bus write has arrived for the full window does the erase of every queued sector begin. Any unrelated write inside the window drops the whole request. Durations are parameters in clock cycles.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset every array byte reads FFh and reads return array data (no operation pending).
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by one write of (A, D) program byte A (array index = A[MEM_AW-1:0]) to old AND D, so bits can only be cleared.
- R3: For PROG_CYC cycles after the program data write, reads at any address return a status byte whose bit 7 is the inverse of D bit 7 and whose other bits are 0; afterwards the array value is visible.
- R4: Bus writes made while a program operation runs have no effect.
- R5: A wrong data value or wrong address in any unlock or command write returns the decoder to its idle state, so the remaining writes of that sequence change nothing.
- R6: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a whole-array erase at once; while it runs reads return 08h (bit 7 = 0, bit 3 = 1) and after ERASE_CYC cycles every byte reads FFh.
- R7: The same five-write prefix ending in 30h at any address queues the sector given by address bits [MEM_AW-1:MEM_AW-4] and opens the window; while open, reads return 00h (bit 3 = 0, bit 7 = 0), and after WIN_CYC cycles with no write the erase starts and reads return 08h.
- R8: A 30h write while the window is open adds the sector of its address to the pending set and restarts the full WIN_CYC count.
- R9: Any write inside the window whose data is neither 30h nor B0h closes the window and returns to read mode with nothing erased.
- R10: A B0h write inside the window restarts the count but queues no sector.
- R11: Bus writes made while an erase runs have no effect.
- R12: A sector erase sets only the bytes of the queued sectors to FFh; all other bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write per cycle it is high |
| addr | input | 11 | Bus write address |
| wdata | input | 8 | Bus write data |
| rd_addr | input | MEM_AW | Read address into the array |
| rdata | output | 8 | Array data, or status byte while an operation is pending |

## Verification
The assertions take for granted that each cycle with wr_en high is one complete bus write with address and data valid in that same cycle, and that the host never needs erase suspend, so B0h inside the window is only a timer restart. The stimulus drives every write for exactly one clock from the falling edge, leaves at least one idle cycle between writes, and keeps the spacing of writes inside the erase window below WIN_CYC so the restart behaviour is exercised without accidental expiry.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int          BUS_AW     = 11;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  OP_PROGRAM = 8'hA0;
  localparam logic [7:0]  OP_SETUP   = 8'h80;
  localparam logic [7:0]  OP_WHOLE   = 8'h10;
  localparam logic [7:0]  OP_SECTOR  = 8'h30;
  localparam logic [7:0]  OP_HOLD    = 8'hB0;
  localparam logic [BUS_AW-1:0] LOC_FIRST  = 11'h555;
  localparam logic [BUS_AW-1:0] LOC_SECOND = 11'h2AA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PDATA, SQ_SETUP, SQ_EK1, SQ_EK2
  } seq_state_t;

  // status byte: bit 7 is the poll bit, bit 3 says the window has closed
  function automatic logic [7:0] status_byte(input logic poll, input logic closed);
    return {poll, 3'b000, closed, 3'b000};
  endfunction

  // a program can only clear bits
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              prog_req,
  output logic              chip_req,
  output logic              sect_req
);

  seq_state_t st, st_nx;
  logic key1_hit, key2_hit, at_first;

  assign at_first = (addr == LOC_FIRST);
  assign key1_hit = at_first && (wdata == KEY_FIRST);
  assign key2_hit = (addr == LOC_SECOND) && (wdata == KEY_SECOND);

  always_comb begin
    st_nx    = st;
    prog_req = 1'b0;
    chip_req = 1'b0;
    sect_req = 1'b0;
    if (!en) begin
      st_nx = SQ_IDLE;
    end else if (wr_en) begin
      st_nx = SQ_IDLE;
      case (st)
        SQ_IDLE:  if (key1_hit) st_nx = SQ_K1;
        SQ_K1:    if (key2_hit) st_nx = SQ_K2;
        SQ_K2: begin
          if (at_first && wdata == OP_PROGRAM)    st_nx = SQ_PDATA;
          else if (at_first && wdata == OP_SETUP) st_nx = SQ_SETUP;
        end
        SQ_PDATA: prog_req = 1'b1;
        SQ_SETUP: if (key1_hit) st_nx = SQ_EK1;
        SQ_EK1:   if (key2_hit) st_nx = SQ_EK2;
        SQ_EK2: begin
          if (at_first && wdata == OP_WHOLE) chip_req = 1'b1;
          else if (wdata == OP_SECTOR)       sect_req = 1'b1;
        end
        default:  st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

endmodule

// File: rtl/flash_erase_window.sv
module flash_erase_window
  import flash_cmd_pkg::*;
#(
  parameter int SECT_N  = 16,
  parameter int WIN_CYC = 50
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sect_req,
  input  logic [$clog2(SECT_N)-1:0] sect_sel,
  input  logic                      wr_en,
  input  logic [7:0]                wdata,
  output logic                      win_open,
  output logic                      win_expire,
  output logic [SECT_N-1:0]         win_mask
);

  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt;
  logic add_hit, hold_hit, drop_hit;

  assign add_hit    = win_open && wr_en && (wdata == OP_SECTOR);
  assign hold_hit   = win_open && wr_en && (wdata == OP_HOLD);
  assign drop_hit   = win_open && wr_en && !add_hit && !hold_hit;
  assign win_expire = win_open && !wr_en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_mask <= '0;
      cnt      <= '0;
    end else if (sect_req) begin
      win_open <= 1'b1;
      win_mask <= SECT_N'(1) << sect_sel;
      cnt      <= RELOAD;
    end else if (add_hit) begin
      win_mask <= win_mask | (SECT_N'(1) << sect_sel);
      cnt      <= RELOAD;
    end else if (hold_hit) begin
      cnt      <= RELOAD;
    end else if (drop_hit || win_expire) begin
      win_open <= 1'b0;
      win_mask <= '0;
    end else if (win_open) begin
      cnt      <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int SECT_N    = 16,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [MEM_AW-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              chip_req,
  input  logic              win_expire,
  input  logic [SECT_N-1:0] win_mask,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic              prog_busy,
  output logic              erase_busy,
  output logic              prog_done,
  output logic              erase_done,
  output logic              prog_poll,
  output logic [7:0]        mem_q
);

  localparam int DEPTH  = 1 << MEM_AW;
  localparam int SECT_D = DEPTH / SECT_N;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] op_addr;
  logic [7:0]        op_data;
  logic [SECT_N-1:0] erase_set;
  logic [CW-1:0]     cnt;
  logic [DEPTH-1:0]  wipe;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wipe
    assign wipe[g] = erase_set[g / SECT_D];
  end

  assign prog_done  = prog_busy  && (cnt == '0);
  assign erase_done = erase_busy && (cnt == '0);
  assign prog_poll  = ~op_data[7];
  assign mem_q      = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_busy  <= 1'b0;
      erase_busy <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
      erase_set  <= '0;
      cnt        <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_req) begin
      prog_busy <= 1'b1;
      op_addr   <= prog_addr;
      op_data   <= prog_data;
      cnt       <= CW'(PROG_CYC - 1);
    end else if (chip_req || win_expire) begin
      erase_busy <= 1'b1;
      erase_set  <= chip_req ? '1 : win_mask;
      cnt        <= CW'(ERASE_CYC - 1);
    end else if (prog_done) begin
      prog_busy    <= 1'b0;
      mem[op_addr] <= prog_merge(mem[op_addr], op_data);
    end else if (erase_done) begin
      erase_busy <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (wipe[i]) mem[i] <= 8'hFF;
      end
    end else if (prog_busy || erase_busy) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int SECT_N    = 16,
  parameter int PROG_CYC  = 16,
  parameter int WIN_CYC   = 50,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [10:0]       addr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rdata
);

  localparam int SAW = $clog2(SECT_N);

  logic prog_req, chip_req, sect_req, seq_en;
  logic prog_busy, erase_busy, prog_done, erase_done, prog_poll;
  logic win_open, win_expire;
  logic [SECT_N-1:0] win_mask;
  logic [SAW-1:0]    sect_sel;
  logic [7:0]        mem_q;

  assign seq_en   = !(prog_busy || erase_busy || win_open);
  assign sect_sel = addr[MEM_AW-1 -: SAW];

  flash_seq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en(seq_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .prog_req(prog_req), .chip_req(chip_req), .sect_req(sect_req)
  );

  flash_erase_window #(.SECT_N(SECT_N), .WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .sect_req(sect_req), .sect_sel(sect_sel),
    .wr_en(wr_en), .wdata(wdata), .win_open(win_open),
    .win_expire(win_expire), .win_mask(win_mask)
  );

  flash_op_engine #(.MEM_AW(MEM_AW), .SECT_N(SECT_N), .PROG_CYC(PROG_CYC),
                    .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req),
    .prog_addr(addr[MEM_AW-1:0]), .prog_data(wdata), .chip_req(chip_req),
    .win_expire(win_expire), .win_mask(win_mask), .rd_addr(rd_addr),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .prog_done(prog_done),
    .erase_done(erase_done), .prog_poll(prog_poll), .mem_q(mem_q)
  );

  always_comb begin
    if (prog_busy)       rdata = status_byte(prog_poll, 1'b0);
    else if (erase_busy) rdata = status_byte(1'b0, 1'b1);
    else if (win_open)   rdata = status_byte(1'b0, 1'b0);
    else                 rdata = mem_q;
  end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       prog_busy,
  input logic       erase_busy,
  input logic       erase_done,
  input logic       win_open,
  input logic       win_expire
);

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prog_busy, erase_busy, win_open}) <= 1);  // R4
  AST_PROG_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy && wr_en |=> !win_open && !erase_busy);  // R4
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> rdata[6:0] == 7'd0);  // R3
  AST_ERASE_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> rdata == 8'h08);  // R6
  AST_WIN_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> rdata[7] == 1'b0 && rdata[3] == 1'b0);  // R7
  AST_EXPIRE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> erase_busy);  // R7
  AST_WIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && wr_en && (wdata == 8'h30 || wdata == 8'hB0) |=> win_open);  // R8
  AST_WIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && wr_en && wdata != 8'h30 && wdata != 8'hB0 |=> !win_open && !erase_busy);  // R9
  AST_ERASE_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy && !erase_done |=> erase_busy);  // R11

endmodule

bind flash_cmd_top flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .prog_busy(prog_busy), .erase_busy(erase_busy), .erase_done(erase_done),
  .win_open(win_open), .win_expire(win_expire)
);

// File: tb/flash_cmd_top_test.sv
module flash_cmd_top_test;

  localparam int PROG_CYC  = 16;
  localparam int WIN_CYC   = 50;
  localparam int ERASE_CYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_top #(.PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata)
  );

  // {address, program data, expected byte afterwards}
  localparam logic [26:0] VEC [6] = '{
    {11'h010, 8'hA5, 8'hA5},
    {11'h010, 8'h3C, 8'h24},
    {11'h010, 8'hFF, 8'h24},
    {11'h123, 8'h00, 8'h00},
    {11'h0FF, 8'h5A, 8'h5A},
    {11'h020, 8'h80, 8'h80}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rdata;
  endtask

  task automatic program_seq(input logic [10:0] a, input logic [7:0] d);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'hA0);
    bus_write(a, d);
  endtask

  task automatic erase_prefix();
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h80);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: erased after reset
    peek(8'h00, v); check("R1 byte 00", v, 8'hFF);
    peek(8'hFF, v); check("R1 byte FF", v, 8'hFF);

    // R2 / R3: table of program operations
    for (int k = 0; k < 6; k++) begin
      program_seq(VEC[k][26:16], VEC[k][15:8]);
      peek(VEC[k][23:16], v);
      check("R3 poll first", v, VEC[k][15] ? 8'h00 : 8'h80);
      repeat (PROG_CYC - 1) @(negedge clk);
      peek(VEC[k][23:16], v);
      check("R3 poll last", v, VEC[k][15] ? 8'h00 : 8'h80);
      @(negedge clk);
      peek(VEC[k][23:16], v);
      check("R2 stored and-merge", v, VEC[k][7:0]);
    end

    // R4: writes during a program are ignored
    program_seq(11'h030, 8'h11);
    program_seq(11'h031, 8'h22);
    repeat (PROG_CYC) @(negedge clk);
    peek(8'h30, v); check("R4 first program", v, 8'h11);
    peek(8'h31, v); check("R4 ignored program", v, 8'hFF);

    // R5: wrong unlock data, then wrong unlock address
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h54);
    bus_write(11'h555, 8'hA0);
    bus_write(11'h032, 8'h00);
    peek(8'h32, v); check("R5 bad data", v, 8'hFF);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AB, 8'h55);
    bus_write(11'h555, 8'hA0);
    bus_write(11'h033, 8'h00);
    peek(8'h33, v); check("R5 bad address", v, 8'hFF);

    // R7 / R8 / R10 / R12: sectors 1 and 15 queued, window restarted
    erase_prefix();
    bus_write(11'h014, 8'h30);
    peek(8'h10, v); check("R7 window status", v, 8'h00);
    repeat (WIN_CYC - 3) @(negedge clk);
    bus_write(11'h0F3, 8'h30);
    repeat (WIN_CYC - 3) @(negedge clk);
    peek(8'h10, v); check("R8 window reopened", v, 8'h00);
    bus_write(11'h000, 8'hB0);
    repeat (WIN_CYC - 1) @(negedge clk);
    peek(8'h10, v); check("R10 window held", v, 8'h00);
    @(negedge clk);
    peek(8'h10, v); check("R7 erase started", v, 8'h08);
    repeat (ERASE_CYC) @(negedge clk);
    peek(8'h10, v); check("R12 sector 1 erased", v, 8'hFF);
    peek(8'hFF, v); check("R8 sector 15 erased", v, 8'hFF);
    peek(8'h23, v); check("R12 sector 2 kept", v, 8'h00);
    peek(8'h20, v); check("R12 sector 2 kept", v, 8'h80);
    peek(8'h00, v); check("R10 sector 0 kept", v, 8'hFF);
    peek(8'h30, v); check("R12 sector 3 kept", v, 8'h11);

    // R9: other data in the window abandons it
    erase_prefix();
    bus_write(11'h020, 8'h30);
    bus_write(11'h020, 8'h00);
    peek(8'h20, v); check("R9 read mode at once", v, 8'h80);
    repeat (WIN_CYC + ERASE_CYC + 2) @(negedge clk);
    peek(8'h20, v); check("R9 nothing erased", v, 8'h80);

    // R6 / R11: whole-array erase, writes ignored while it runs
    erase_prefix();
    bus_write(11'h555, 8'h10);
    peek(8'h20, v); check("R6 erase status", v, 8'h08);
    program_seq(11'h040, 8'h00);
    repeat (ERASE_CYC - 9) @(negedge clk);
    peek(8'h20, v); check("R11 still erasing", v, 8'h08);
    repeat (10) @(negedge clk);
    peek(8'h20, v); check("R6 byte 20 erased", v, 8'hFF);
    peek(8'h23, v); check("R6 byte 23 erased", v, 8'hFF);
    peek(8'h30, v); check("R6 byte 30 erased", v, 8'hFF);
    peek(8'h40, v); check("R11 program ignored", v, 8'hFF);

    // R1: reset returns the array to erased state
    program_seq(11'h050, 8'h0F);
    repeat (PROG_CYC) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(8'h50, v); check("R1 after reset", v, 8'hFF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule